// File: doc/BRIEF.md
# Self-Clearing Reset Pulse Register

This block is one byte-wide control register on a simple register bus. Software writes ones to it to request resets. Each one that is written starts a reset pulse of a fixed length on its own output line. Once that pulse ends, the bit clears itself, so software never has to write the register a second time to release a reset.

There are two kinds of reset. A full reset drives a "restore defaults" strobe to the configuration register file. A partial reset clears only datapath state and leaves configuration alone.

The eight bits cover the whole device, a demodulator, a convolutional decoder, a byte aligner and a descrambler. A device-level request fans out to the matching sub-block lines. Software can read the register at any time to see which pulses are still running.

Top module: `rst_pulse_ctl`

## Requirements
- R1: After reset every pulse output and `cfg_restore` are low, and a read of the control address returns 0x00.
- R2: A write to the control address with bit n set raises that bit's output on the first clock after the write edge. The bit-to-output map is: bit 7 `chip_full_rst`, bit 6 `chip_part_rst`, bit 5 `demod_full_rst`, bit 4 `demod_part_rst`, bit 3 `dec_full_rst`, bit 2 `dec_part_rst`, bit 1 `align_part_rst`, bit 0 `descr_part_rst`.
- R3: A pulse from a single write stays high for exactly PULSE_CYCLES (default 3) clock periods.
- R4: While a pulse runs, its bit reads back as 1. The bit then clears itself, and after the pulse the register reads 0x00.
- R5: Writing bit 7 also pulses bits 5, 4, 3, 2, 1 and 0 for the same window.
- R6: Writing bit 6 also pulses bits 4, 2, 1 and 0, and does not pulse bits 7, 5 or 3.
- R7: `cfg_restore` is high exactly while any full-reset pulse (bit 7, 5 or 3) is high. It stays low during pulses that are partial only, so a partial reset leaves the configuration contents unchanged.
- R8: Writing a one to a bit whose pulse is running restarts that bit's count, so the pulse stays high for PULSE_CYCLES periods after the new write.
- R9: Writing zeros has no effect. A write to any other address has no effect, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: active-pulse bits at the control address, otherwise 0 |
| chip_full_rst | output | 1 | Device full reset pulse |
| chip_part_rst | output | 1 | Device partial reset pulse |
| demod_full_rst | output | 1 | Demodulator full reset pulse |
| demod_part_rst | output | 1 | Demodulator partial reset pulse |
| dec_full_rst | output | 1 | Convolutional decoder full reset pulse |
| dec_part_rst | output | 1 | Convolutional decoder partial reset pulse |
| align_part_rst | output | 1 | Byte aligner partial reset pulse |
| descr_part_rst | output | 1 | Descrambler partial reset pulse |
| cfg_restore | output | 1 | Restore-defaults strobe to the configuration register file |

## Verification
Some rules are checked by assertions on every cycle:
- device-level pulses imply their sub-block pulses;
- the restore strobe tracks the full-reset lines;
- a hit write starts or keeps a pulse;
- a count in its last cycle drops the line;
- a write of zeros to an idle register starts nothing.

The exact three-cycle width, the readback value in each cycle, and the behaviour after a restart mid-pulse are shown only by the bench's scenarios. The bench sweeps all 256 write values and checks the outputs after each write. The fact that a partial reset leaves a preloaded configuration value alone is also shown only by the bench, through a small configuration model driven by `cfg_restore`.

// File: rtl/rst_pulse_ctl.sv
module rst_pulse_ctl #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h40,
  parameter int PULSE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              chip_full_rst,
  output logic              chip_part_rst,
  output logic              demod_full_rst,
  output logic              demod_part_rst,
  output logic              dec_full_rst,
  output logic              dec_part_rst,
  output logic              align_part_rst,
  output logic              descr_part_rst,
  output logic              cfg_restore
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);
  localparam logic [7:0] SUB_ALL   = 8'h3F;
  localparam logic [7:0] SUB_PART  = 8'h17;
  localparam logic [7:0] FULL_MASK = 8'hA8;

  logic       addr_hit, wr_hit;
  logic [7:0] req, load, act_d, pulse_q;
  logic       restore_q;

  assign addr_hit = (bus_addr == CTRL_ADDR);
  assign wr_hit   = bus_we && addr_hit;
  assign req  = bus_wdata | ({8{bus_wdata[7]}} & SUB_ALL) | ({8{bus_wdata[6]}} & SUB_PART);
  assign load = wr_hit ? req : 8'h00;

  for (genvar i = 0; i < 8; i++) begin : g_bit
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
      if (load[i])            cnt_d = LOAD;
      else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
      else                    cnt_d = '0;
    end
    assign act_d[i] = (cnt_d != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q      <= '0;
        pulse_q[i] <= 1'b0;
      end else begin
        cnt_q      <= cnt_d;
        pulse_q[i] <= act_d[i];
      end
    end

    // R2 / R8: a hit write carrying this bit starts or restarts its pulse
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load[i] |=> pulse_q[i]);
    // R4: last counted cycle without a new write ends the pulse
    p_selfclear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CW'(1) && !load[i]) |=> !pulse_q[i]);
    // R3: a pulse never lasts a single cycle when the width is longer
    p_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((PULSE_CYCLES > 1) && $rose(pulse_q[i])) |=> pulse_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restore_q <= 1'b0;
    else        restore_q <= |(act_d & FULL_MASK);
  end

  assign bus_rdata      = addr_hit ? pulse_q : 8'h00;
  assign chip_full_rst  = pulse_q[7];
  assign chip_part_rst  = pulse_q[6];
  assign demod_full_rst = pulse_q[5];
  assign demod_part_rst = pulse_q[4];
  assign dec_full_rst   = pulse_q[3];
  assign dec_part_rst   = pulse_q[2];
  assign align_part_rst = pulse_q[1];
  assign descr_part_rst = pulse_q[0];
  assign cfg_restore    = restore_q;

  p_chip_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q[7] |-> (&pulse_q[5:0]));
  p_chip_part_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q[6] |-> (pulse_q[4] && pulse_q[2] && pulse_q[1] && pulse_q[0]));
  p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_restore == (|(pulse_q & FULL_MASK)));
  p_zero_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_wdata == 8'h00 && pulse_q == 8'h00) |=> pulse_q == 8'h00);
endmodule

// File: tb/sim_rst_pulse_ctl.sv
module sim_rst_pulse_ctl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CTRL = 8'h40;
  localparam logic [7:0] OTHER = 8'h41;
  localparam logic [7:0] CFG_DEFAULT = 8'h00;

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = CTRL, bus_wdata = 0, bus_rdata;
  logic bus_we = 0;
  logic chip_full_rst, chip_part_rst, demod_full_rst, demod_part_rst;
  logic dec_full_rst, dec_part_rst, align_part_rst, descr_part_rst, cfg_restore;
  logic [7:0] outs;
  logic [7:0] cfg_model;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_pulse_ctl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chip_full_rst(chip_full_rst), .chip_part_rst(chip_part_rst),
    .demod_full_rst(demod_full_rst), .demod_part_rst(demod_part_rst),
    .dec_full_rst(dec_full_rst), .dec_part_rst(dec_part_rst),
    .align_part_rst(align_part_rst), .descr_part_rst(descr_part_rst),
    .cfg_restore(cfg_restore));

  assign outs = {chip_full_rst, chip_part_rst, demod_full_rst, demod_part_rst,
                 dec_full_rst, dec_part_rst, align_part_rst, descr_part_rst};

  always_ff @(posedge clk) if (cfg_restore) cfg_model <= CFG_DEFAULT;

  function automatic logic [7:0] expand(input logic [7:0] v);
    return v | (v[7] ? 8'h3F : 8'h00) | (v[6] ? 8'h17 : 8'h00);
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    step();
    bus_we = 0; bus_wdata = 0; bus_addr = CTRL;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] e;
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset state
    check8("R1 outputs", outs, 8'h00);
    check8("R1 restore", {7'b0, cfg_restore}, 8'h00);
    check8("R1 readback", bus_rdata, 8'h00);

    // R2 R3 R4 R5 R6 R7: sweep every write value from idle
    for (int v = 0; v < 256; v++) begin
      e = expand(8'(v));
      write(CTRL, 8'(v));
      for (int k = 1; k <= 4; k++) begin
        if (k > 1) step();
        check8("R2/R3/R5/R6 outputs", outs, (k <= 3) ? e : 8'h00);
        check8("R4 readback", bus_rdata, (k <= 3) ? e : 8'h00);
        check8("R7 restore", {7'b0, cfg_restore},
               {7'b0, (k <= 3) && ((e & 8'hA8) != 0)});
      end
    end

    // R8 restart of a running pulse
    write(CTRL, 8'h01);
    check8("R8 first", outs, 8'h01);
    step();
    check8("R8 second", outs, 8'h01);
    write(CTRL, 8'h01);
    for (int k = 1; k <= 3; k++) begin
      check8("R8 extended", outs, 8'h01);
      step();
    end
    check8("R8 end", outs, 8'h00);

    // R9 zeros and foreign address
    write(CTRL, 8'h00);
    check8("R9 zero write", outs, 8'h00);
    write(OTHER, 8'hFF);
    for (int k = 1; k <= 3; k++) begin
      check8("R9 other address", outs, 8'h00);
      step();
    end
    bus_addr = OTHER;
    write(CTRL, 8'h02);
    bus_addr = OTHER;
    #1;
    check8("R9 other read", bus_rdata, 8'h00);
    bus_addr = CTRL;
    repeat (4) step();

    // R7 partial reset keeps preloaded config, full reset restores default
    cfg_model = 8'h5A;
    write(CTRL, 8'h57);
    repeat (4) step();
    check8("R7 partial keeps config", cfg_model, 8'h5A);
    write(CTRL, 8'h08);
    repeat (4) step();
    check8("R7 full restores config", cfg_model, CFG_DEFAULT);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule